// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block keeps the settings a clock synthesizer needs: a 9-bit feedback multiplier M, a 2-bit output divider code N and a 2-bit test select T. It has two ways to load them. In parallel mode a strobe line controls the M and N pins. While the strobe is low the pins pass through to the outputs. A rising strobe captures the pins. In serial mode the strobe is held high and a three-wire port fills a 14-bit shift register. That port has data, clock and load lines. A rising load line moves the frame into M, N and T.

The block also drives a test pin. The pin chooses one of four sources by T. It is held low in parallel mode and while the master reset is asserted. The master reset never changes the stored M, N or T.

All strobe and serial lines come from outside the system clock domain. Each one passes through a two-stage synchronizer. Edges are then found on the synchronized samples, so the whole block runs on one clock.

Top module: `synth_cfg_port`

## Requirements
- R1: Every strobe, serial line and M/N pin passes through two synchronizer flops. A change on an input reaches M/N on the third rising system-clock edge after the change, and not before.
- R2: While the synchronized parallel strobe is low, `m_val`/`n_val` follow the synchronized pins.
- R3: When the parallel strobe rises, the pins present at that point are captured. M and N then stay fixed while the strobe stays high and no serial load occurs. Following the pins resumes when the strobe goes low.
- R4: The shift register shifts in the serial data bit on each rising serial clock, but only while the strobe is high (serial mode). Serial clock edges while the strobe is low leave the register untouched.
- R5: A rising serial load copies the frame into the outputs. Shifted first to last, the frame is T1, T0, one unused bit, N1, N0, then M8 down to M0. M is plain binary, so 25 is 000011001.
- R6: While the serial load line is high, each rising serial clock shifts and at once copies the new frame into M, N and T.
- R7: After the serial load line falls, further serial clocks shift the register but leave M, N and T frozen.
- R8: A serial event that falls on the first cycle of a high strobe is ignored. The parallel capture wins, and T is untouched by the parallel path.
- R9: The test pin is low while the strobe is low. Otherwise it depends on T: 00 gives low, 01 gives the synchronized serial data, 10 gives the feedback divider input, and 11 gives the output clock input.
- R10: Master reset drives the test pin low and does not change M, N or T.
- R11: After power-on reset, M, N and T are zero and the shift register is clear. A load with no shifts therefore yields all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mrst | input | 1 | Master reset; gates the test pin only |
| par_ld | input | 1 | Parallel load strobe |
| m_pin | input | 9 | Parallel M value |
| n_pin | input | 2 | Parallel N code |
| sclk | input | 1 | Serial clock |
| sdat | input | 1 | Serial data |
| sld | input | 1 | Serial load line |
| fb_clk | input | 1 | Feedback divider output, a test source |
| out_clk | input | 1 | Synthesized clock, a test source |
| m_val | output | 9 | Active M value |
| n_val | output | 2 | Active N code |
| t_val | output | 2 | Active test select |
| test_out | output | 1 | Test pin |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the parallel capture and a serial load. The bench raises the strobe and the serial load line in the same system cycle. It then checks that M and N carry the pins and not the shift register contents, and that T keeps its earlier value.

The second pair is a shift and a load. The bench clocks serial data while the load line is held high. Each shifted frame must then appear on the outputs three edges after the serial clock rises.

A behavioural model built from queues of input samples is compared with every output on every clock.

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
  parameter int MW = 9,
  parameter int NW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mrst,
  input  logic          par_ld,
  input  logic [MW-1:0] m_pin,
  input  logic [NW-1:0] n_pin,
  input  logic          sclk,
  input  logic          sdat,
  input  logic          sld,
  input  logic          fb_clk,
  input  logic          out_clk,
  output logic [MW-1:0] m_val,
  output logic [NW-1:0] n_val,
  output logic [1:0]    t_val,
  output logic          test_out
);
  localparam int TW = 2;
  localparam int FW = TW + 1 + NW + MW;
  localparam int SW = MW + NW + 4;

  logic [SW-1:0] s1, s2;
  logic [MW-1:0] m_s2;
  logic [NW-1:0] n_s2;
  logic          p_s2, sc_s2, sd_s2, sl_s2;
  logic          p_d, sc_d, sl_d;
  logic [FW-1:0] sh, frame;
  logic          unused_spare;
  logic          sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      p_d <= 1'b0;
      sc_d <= 1'b0;
      sl_d <= 1'b0;
    end else begin
      s1 <= {m_pin, n_pin, par_ld, sclk, sdat, sld};
      s2 <= s1;
      p_d <= p_s2;
      sc_d <= sc_s2;
      sl_d <= sl_s2;
    end

  assign {m_s2, n_s2, p_s2, sc_s2, sd_s2, sl_s2} = s2;

  wire ser_act = p_s2 & p_d;
  wire sc_rise = sc_s2 & ~sc_d;
  wire sl_rise = sl_s2 & ~sl_d;
  wire do_shift = ser_act & sc_rise;
  wire do_load = ser_act & ((sl_s2 & sc_rise) | sl_rise);

  assign frame = do_shift ? {sh[FW-2:0], sd_s2} : sh;
  assign unused_spare = frame[MW+NW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0;
      m_val <= '0;
      n_val <= '0;
      t_val <= '0;
    end else begin
      if (do_shift) sh <= frame;
      if (!ser_act) begin
        m_val <= m_s2;
        n_val <= n_s2;
      end else if (do_load) begin
        t_val <= frame[FW-1 -: TW];
        n_val <= frame[MW +: NW];
        m_val <= frame[MW-1:0];
      end
    end

  always_comb
    case (t_val)
      2'b00:   sel = 1'b0;
      2'b01:   sel = sd_s2;
      2'b10:   sel = fb_clk;
      default: sel = out_clk;
    endcase

  assign test_out = sel & p_s2 & ~mrst;
endmodule

// File: rtl/synth_cfg_port_chk.sv
module synth_cfg_port_chk #(
  parameter int MW = 9,
  parameter int NW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mrst,
  input logic          test_out,
  input logic [MW-1:0] m_val,
  input logic [NW-1:0] n_val,
  input logic [1:0]    t_val,
  input logic          p_s2,
  input logic          p_d,
  input logic          sl_s2,
  input logic          sl_d,
  input logic [MW-1:0] m_s2
);
  AST_MRST_TEST_LOW: assert property (@(posedge clk) disable iff (!rst_n) mrst |-> !test_out); // R10
  AST_PAR_TEST_LOW: assert property (@(posedge clk) disable iff (!rst_n) !p_s2 |-> !test_out); // R9
  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) !p_s2 |=> (m_val == $past(m_s2))); // R2
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (p_s2 && p_d && !sl_s2 && !sl_d) |=> $stable({m_val, n_val, t_val})); // R7
  AST_T_PAR_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_s2 || !p_d) |=> $stable(t_val)); // R8
endmodule

bind synth_cfg_port synth_cfg_port_chk #(.MW(MW), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mrst(mrst), .test_out(test_out),
  .m_val(m_val), .n_val(n_val), .t_val(t_val),
  .p_s2(p_s2), .p_d(p_d), .sl_s2(sl_s2), .sl_d(sl_d), .m_s2(m_s2)
);

// File: tb/sim_synth_cfg_port.sv
module sim_synth_cfg_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mr = 0, pl = 0, scl = 0, sda = 0, sldv = 0, fb = 0, oc = 0;
  logic [8:0] mp = '0;
  logic [1:0] np = '0;
  logic [8:0] m_val;
  logic [1:0] n_val, t_val;
  logic test_out;

  int checks = 0, fails = 0;
  bit armed = 0;
  string phase = "R11";

  always #4 clk = ~clk;

  synth_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .mrst(mr), .par_ld(pl), .m_pin(mp), .n_pin(np),
    .sclk(scl), .sdat(sda), .sld(sldv), .fb_clk(fb), .out_clk(oc),
    .m_val(m_val), .n_val(n_val), .t_val(t_val), .test_out(test_out)
  );

  logic [14:0] hq[$];
  logic [8:0] em;
  logic [1:0] en, et;
  logic [13:0] esh;

  always @(posedge clk) begin
    logic [14:0] cur, old;
    if (!rst_n) begin
      hq.delete();
      repeat (4) hq.push_back(15'd0);
      em = 0; en = 0; et = 0; esh = 0;
    end else begin
      hq.push_front({mp, np, pl, scl, sda, sldv});
      void'(hq.pop_back());
      cur = hq[2];
      old = hq[3];
      if (!cur[3] || !old[3]) begin
        em = cur[14:6];
        en = cur[5:4];
      end else begin
        if (cur[2] && !old[2]) begin
          esh = {esh[12:0], cur[1]};
          if (cur[0]) begin et = esh[13:12]; en = esh[10:9]; em = esh[8:0]; end
        end else if (cur[0] && !old[0]) begin
          et = esh[13:12]; en = esh[10:9]; em = esh[8:0];
        end
      end
    end
  end

  always @(negedge clk) begin
    logic et_out;
    if (armed && rst_n) begin
      case (et)
        2'd0: et_out = 0;
        2'd1: et_out = hq[1][1];
        2'd2: et_out = fb;
        default: et_out = oc;
      endcase
      if (mr || !hq[1][3]) et_out = 0;
      checks++;
      if ({m_val, n_val, t_val, test_out} !== {em, en, et, et_out}) begin
        fails++;
        $display("FAIL %s: cycle compare act m=%0d n=%0d t=%0d tst=%0b exp m=%0d n=%0d t=%0d tst=%0b",
                 phase, m_val, n_val, t_val, test_out, em, en, et, et_out);
      end
    end
  end

  task automatic step(int k = 1);
    repeat (k) begin @(posedge clk); #2; end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    @(negedge clk); #1;
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [13:0] f);
    for (int i = 13; i >= 0; i--) begin
      sda = f[i]; step(2);
      scl = 1; step(3);
      scl = 0; step(2);
    end
  endtask

  task automatic pulse_ld();
    sldv = 1; step(3);
    sldv = 0; step(4);
  endtask

  function automatic logic [13:0] mk(logic [1:0] t, logic [1:0] n, logic [8:0] m);
    return {t, 1'b0, n, m};
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1; armed = 1;
    step(1);
    phase = "R11";
    chk(m_val == 0 && n_val == 0 && t_val == 0 && test_out == 0, "R11 reset state", {m_val, t_val}, 0);

    phase = "R1";
    mp = 9'd25;
    step(2);
    chk(m_val == 0, "R1 no early change", m_val, 0);
    step(1);
    chk(m_val == 25, "R1 third edge", m_val, 25);

    phase = "R2";
    mp = 9'd300; np = 2'd3; step(4);
    chk(m_val == 300 && n_val == 3, "R2 follow a", m_val, 300);
    mp = 9'd1; np = 2'd1; step(4);
    chk(m_val == 1 && n_val == 1, "R2 follow b", m_val, 1);

    phase = "R4";
    sda = 1;
    for (int i = 0; i < 5; i++) begin scl = 1; step(3); scl = 0; step(3); end
    sda = 0;

    phase = "R3";
    mp = 9'd100; np = 2'd2; step(4);
    pl = 1; step(4);
    mp = 9'd7; np = 2'd0; step(4);
    chk(m_val == 100 && n_val == 2, "R3 held", m_val, 100);

    phase = "R4";
    pulse_ld();
    chk(m_val == 0 && n_val == 0 && t_val == 0, "R4 R11 no shift in parallel mode", m_val, 0);

    phase = "R5";
    send(mk(2'b01, 2'b10, 9'd25));
    chk(m_val == 0, "R7 no change before load", m_val, 0);
    pulse_ld();
    chk(m_val == 25 && n_val == 2 && t_val == 1, "R5 frame load", {m_val, n_val, t_val}, {9'd25, 2'd2, 2'd1});

    phase = "R9";
    sda = 1; step(3);
    chk(test_out == 1, "R9 serial data select", test_out, 1);
    sda = 0; step(3);
    chk(test_out == 0, "R9 serial data select low", test_out, 0);

    phase = "R10";
    sda = 1; mr = 1; step(4);
    chk(test_out == 0 && m_val == 25 && t_val == 1, "R10 master reset", {test_out, m_val}, 25);
    mr = 0; sda = 0; step(2);

    phase = "R9";
    send(mk(2'b10, 2'b01, 9'd511)); pulse_ld();
    for (int i = 0; i < 6; i++) begin fb = ~fb; step(1); end
    fb = 1; step(1);
    chk(test_out == 1 && m_val == 511, "R9 feedback select", test_out, 1);
    send(mk(2'b11, 2'b00, 9'd256)); pulse_ld();
    for (int i = 0; i < 6; i++) begin oc = ~oc; step(1); end
    oc = 1; step(1);
    chk(test_out == 1 && m_val == 256, "R9 clock select", test_out, 1);
    send(mk(2'b00, 2'b11, 9'd3)); pulse_ld();
    oc = 1; fb = 1; sda = 1; step(3);
    chk(test_out == 0 && n_val == 3, "R9 low select", test_out, 0);
    sda = 0;

    phase = "R6";
    send(mk(2'b11, 2'b00, 9'd0)); pulse_ld();
    pl = 0; step(4);
    chk(test_out == 0 && t_val == 3, "R9 parallel forces low", test_out, 0);
    pl = 1; step(4);
    sldv = 1; step(4);
    send(mk(2'b01, 2'b01, 9'd170));
    chk(m_val == 170 && t_val == 1 && n_val == 1, "R6 transparent serial", m_val, 170);

    phase = "R7";
    sldv = 0; step(4);
    send(mk(2'b10, 2'b10, 9'd85));
    chk(m_val == 170 && t_val == 1, "R7 frozen after load falls", m_val, 170);
    pulse_ld();
    chk(m_val == 85 && t_val == 2, "R5 later load", m_val, 85);

    phase = "R8";
    mp = 9'd42; np = 2'd3; pl = 0; step(4);
    pl = 1; sldv = 1; step(5);
    sldv = 0; step(4);
    chk(m_val == 42 && n_val == 3 && t_val == 2, "R8 parallel wins", m_val, 42);

    step(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule